// File: doc/BRIEF.md
# Event Input Edge Trigger Channel

This block is one channel of an external event request unit. Two clock-synchronous raw inputs, A and B, can each be inverted, and are then merged by a selectable function (A alone, B alone, OR, AND) into one event signal. The channel compares that signal with its value from the previous clock to find rising and falling edges. Per-edge enable bits decide which edges count as events.

Each counted event updates a status flag and, when pulse generation is enabled, produces a one-cycle trigger pulse on one of four output lines. The flag works in one of two modes. In sticky mode it latches high until software writes it low. In level-rebuild mode every edge rewrites it: a rising edge loads the rising-edge enable and a falling edge loads the falling-edge enable, so the flag follows the level of the chosen polarity. All configuration sits in one 32-bit control word that software writes in a single cycle and reads back combinationally.

The flag is kept by a two-state machine. State `FLAG_LOW` moves to `FLAG_HIGH` on a hardware set or on a software write of 1. State `FLAG_HIGH` moves to `FLAG_LOW` on a hardware clear, which happens only in level-rebuild mode, or on a software write of 0. In every other case each state holds.

Top module: `evtrig_channel`

## Requirements
- R1: After reset the control word reads 0 and every trigger output is 0.
- R2: The control word layout is: bit 0 pulse enable, bit 1 level-rebuild mode, bit 2 rising enable, bit 3 falling enable, bits 6:4 output select, bit 7 flag, bits 9:8 source select, bit 10 invert A, bit 11 invert B. A write with `cfg_wr` high takes effect at the next clock edge. Bits 31:12 always read 0 and ignore writes.
- R3: The event signal is formed from A and B after the per-input inversion. Source select 0 uses A, 1 uses B, 2 uses A OR B, and 3 uses A AND B.
- R4: A rising edge of the event signal (1 this cycle, 0 on the previous clock) is an event only when the rising enable is 1. A falling edge is an event only when the falling enable is 1. The previous-clock value resets to 0.
- R5: With level-rebuild mode 0, an event sets the flag. No edge clears it afterwards; only a software write does.
- R6: With level-rebuild mode 1, any rising edge loads the flag with the rising enable, and any falling edge loads it with the falling enable.
- R7: When the pulse enable is 1 and an event is seen at a clock edge, trigger output `trig_out[sel]` is 1 for exactly the following cycle. The other outputs stay 0. With the pulse enable at 0, no output pulses.
- R8: Output select values 4 to 7 drive no trigger output.
- R9: A software write loads the flag from bit 7. When a hardware flag update (R5 or R6) happens in the same cycle, the hardware value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word readback, including the flag |
| in_a | input | 1 | Raw event input A, already synchronous |
| in_b | input | 1 | Raw event input B, already synchronous |
| trig_out | output | 4 | One-cycle trigger pulses, one line per output unit |

## Verification
The two functions that can land in the same cycle are a software write of the flag bit and a hardware flag update from an edge. The bench provokes this by applying an input transition in the very cycle that `cfg_wr` is high with the opposite flag value. It does this in sticky mode, where a rising event meets a write of 0, and in level-rebuild mode, where a disabled falling edge meets a write of 1. Each case is judged by reading the flag back on the next cycle and expecting the hardware value. The near-exhaustive sweep also writes a flag value with every new configuration, and the bench's model applies the same priority each time.

// File: rtl/evtrig_pkg.sv
package evtrig_pkg;

    // Source combination encodings (control bits 9:8)
    typedef enum logic [1:0] {
        SRC_A   = 2'd0,
        SRC_B   = 2'd1,
        SRC_OR  = 2'd2,
        SRC_AND = 2'd3
    } src_sel_t;

    // Flag state machine
    typedef enum logic {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_t;

    // Stored configuration (flag bit is kept by the state machine)
    typedef struct packed {
        logic       inv_b;
        logic       inv_a;
        src_sel_t   src;
        logic [2:0] out_sel;
        logic       fall_en;
        logic       rise_en;
        logic       level_mode;
        logic       pulse_en;
    } ctrl_t;

endpackage

// File: rtl/evtrig_combine.sv
module evtrig_combine
    import evtrig_pkg::*;
(
    input  logic     raw_a,
    input  logic     raw_b,
    input  logic     inv_a,
    input  logic     inv_b,
    input  src_sel_t src,
    output logic     sig
);
    logic pa, pb;

    always_comb begin
        pa = raw_a ^ inv_a;
        pb = raw_b ^ inv_b;
        unique case (src)
            SRC_A:   sig = pa;
            SRC_B:   sig = pb;
            SRC_OR:  sig = pa | pb;
            SRC_AND: sig = pa & pb;
            default: sig = 1'b0;
        endcase
    end
endmodule

// File: rtl/evtrig_edge.sv
module evtrig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;
endmodule

// File: rtl/evtrig_flag_fsm.sv
module evtrig_flag_fsm
    import evtrig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    input  logic rise_en,
    input  logic fall_en,
    input  logic level_mode,
    input  logic sw_load,
    input  logic sw_val,
    output logic hit,
    output logic flag
);
    flag_state_t state_q, state_d;
    logic hw_upd, hw_val;

    // Hardware update: any edge in level mode, enabled edge in sticky mode
    always_comb begin
        hit    = (rise & rise_en) | (fall & fall_en);
        hw_upd = level_mode ? (rise | fall) : hit;
        hw_val = level_mode ? (rise ? rise_en : fall_en) : 1'b1;
    end

    // Next-state logic; hardware update has priority over software load
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_LOW: begin
                if (hw_upd) begin
                    if (hw_val) state_d = FLAG_HIGH;
                end else if (sw_load && sw_val) begin
                    state_d = FLAG_HIGH;
                end
            end
            FLAG_HIGH: begin
                if (hw_upd) begin
                    if (!hw_val) state_d = FLAG_LOW;
                end else if (sw_load && !sw_val) begin
                    state_d = FLAG_LOW;
                end
            end
            default: state_d = FLAG_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_LOW;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        flag = (state_q == FLAG_HIGH);
    end
endmodule

// File: rtl/evtrig_route.sv
module evtrig_route #(
    parameter int NUM_OUT = 4,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic               pulse_en,
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_OUT-1:0] trig
);
    logic go;
    assign go = fire & pulse_en;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) trig[g] <= 1'b0;
            else        trig[g] <= go && (sel == SEL_W'(g));
        end
    end
endmodule

// File: rtl/evtrig_channel.sv
module evtrig_channel
    import evtrig_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int NUM_OUT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    input  logic               in_a,
    input  logic               in_b,
    output logic [NUM_OUT-1:0] trig_out
);
    localparam int SEL_W  = 3;
    localparam int FLAG_B = 7;
    localparam int USED_W = 12;

    ctrl_t ctrl_q, ctrl_d;
    logic  sig, rise, fall, hit, flag;

    // Unpack a written word into the stored fields (flag bit excluded)
    always_comb begin
        ctrl_d.pulse_en   = cfg_wdata[0];
        ctrl_d.level_mode = cfg_wdata[1];
        ctrl_d.rise_en    = cfg_wdata[2];
        ctrl_d.fall_en    = cfg_wdata[3];
        ctrl_d.out_sel    = cfg_wdata[6:4];
        ctrl_d.src        = src_sel_t'(cfg_wdata[9:8]);
        ctrl_d.inv_a      = cfg_wdata[10];
        ctrl_d.inv_b      = cfg_wdata[11];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (cfg_wr) ctrl_q <= ctrl_d;
    end

    always_comb begin
        cfg_rdata = {{(REG_W-USED_W){1'b0}},
                     ctrl_q.inv_b, ctrl_q.inv_a, ctrl_q.src,
                     flag, ctrl_q.out_sel,
                     ctrl_q.fall_en, ctrl_q.rise_en,
                     ctrl_q.level_mode, ctrl_q.pulse_en};
    end

    evtrig_combine u_comb (
        .raw_a (in_a),
        .raw_b (in_b),
        .inv_a (ctrl_q.inv_a),
        .inv_b (ctrl_q.inv_b),
        .src   (ctrl_q.src),
        .sig   (sig)
    );

    evtrig_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (sig),
        .rise  (rise),
        .fall  (fall)
    );

    evtrig_flag_fsm u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .fall       (fall),
        .rise_en    (ctrl_q.rise_en),
        .fall_en    (ctrl_q.fall_en),
        .level_mode (ctrl_q.level_mode),
        .sw_load    (cfg_wr),
        .sw_val     (cfg_wdata[FLAG_B]),
        .hit        (hit),
        .flag       (flag)
    );

    evtrig_route #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (hit),
        .pulse_en (ctrl_q.pulse_en),
        .sel      (ctrl_q.out_sel),
        .trig     (trig_out)
    );
endmodule

// File: rtl/evtrig_channel_chk.sv
module evtrig_channel_chk #(
    parameter int REG_W   = 32,
    parameter int NUM_OUT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr,
    input logic [REG_W-1:0]   cfg_rdata,
    input logic [NUM_OUT-1:0] trig_out
);
    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[REG_W-1:12] == '0);

    // R7
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trig_out));

    // R7
    pulse_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[0] |=> trig_out == '0);

    // R8
    high_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[6] |=> trig_out == '0);

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[1] && cfg_rdata[7] && !cfg_wr) |=> cfg_rdata[7]);
endmodule

bind evtrig_channel evtrig_channel_chk #(.REG_W(REG_W), .NUM_OUT(NUM_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_rdata (cfg_rdata),
    .trig_out  (trig_out)
);

// File: tb/sim_evtrig_channel.sv
`timescale 1ns/1ps
module sim_evtrig_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_a = 1'b0;
    logic        in_b = 1'b0;
    logic [3:0]  trig_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evtrig_channel u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .in_a(in_a), .in_b(in_b), .trig_out(trig_out)
    );

    // Bench model of the configuration and flag
    logic [11:0] m_cfg = '0;   // bit 7 unused here, flag kept in m_flag
    logic        m_flag = 1'b0;
    logic        m_prev = 1'b0;

    function automatic logic comb_sig(logic a, logic b, logic [11:0] c);
        logic pa, pb;
        pa = a ^ c[10];
        pb = b ^ c[11];
        case (c[9:8])
            2'd0: return pa;
            2'd1: return pb;
            2'd2: return pa | pb;
            default: return pa & pb;
        endcase
    endfunction

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, model the edge, check at next negedge
    task automatic cyc(logic a, logic b, logic wr, logic [31:0] data,
                       string trig_tag, string flag_tag);
        logic s, r, f, ev, upd;
        logic [3:0] etrig;
        logic [31:0] erd;
        in_a = a; in_b = b; cfg_wr = wr; cfg_wdata = data;
        s  = comb_sig(a, b, m_cfg);                       // R3
        r  = s & ~m_prev;
        f  = ~s & m_prev;
        ev = (r & m_cfg[2]) | (f & m_cfg[3]);              // R4
        upd = m_cfg[1] ? (r | f) : ev;
        etrig = '0;
        if (m_cfg[0] && ev && !m_cfg[6]) etrig[m_cfg[5:4]] = 1'b1;  // R7 R8
        if (upd)     m_flag = m_cfg[1] ? (r ? m_cfg[2] : m_cfg[3]) : 1'b1;
        else if (wr) m_flag = data[7];                     // R9
        if (wr) m_cfg = data[11:0];
        m_prev = s;
        @(negedge clk);
        cfg_wr = 1'b0;
        erd = {20'h0, m_cfg[11:8], m_flag, m_cfg[6:0]};
        check32(trig_tag, {28'h0, trig_out}, {28'h0, etrig});
        check32(flag_tag, cfg_rdata, erd);
    endtask

    function automatic logic [1:0] ab_seq(int i);
        case (i)
            0: return 2'd0;  1: return 2'd1;  2: return 2'd3;
            3: return 2'd2;  4: return 2'd0;  5: return 2'd2;
            6: return 2'd3;  7: return 2'd1;  8: return 2'd0;
            9: return 2'd3;  default: return 2'd0;
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        // R1: reset state
        check32("R1 rdata", cfg_rdata, 32'h0);
        check32("R1 trig", {28'h0, trig_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R1 after release", cfg_rdata, 32'h0);

        // R2: upper bits ignored, field readback
        cyc(0, 0, 1'b1, 32'hFFFF_F000 | 32'h0000_0A5C, "R2 trig", "R2 readback");
        cyc(0, 0, 1'b1, 32'h0, "R2 trig", "R2 clear");

        // R3 R4 R5 R6 R7 R8 R9: sweep of all source/invert/enable/mode settings
        for (int k = 0; k < 256; k++) begin
            logic [2:0] osel;
            osel = 3'(k[2:0] ^ k[5:3]);
            w = {20'h0, k[7], k[6], k[5:4], k[4], osel, k[3], k[2], k[1], k[0]};
            cyc(in_a, in_b, 1'b1, w, "R9 cfg trig", "R9 cfg flag");
            for (int i = 0; i < 11; i++) begin
                logic [1:0] p;
                p = ab_seq(i);
                cyc(p[1], p[0], 1'b0, 32'h0,
                    "R7 (R3/R4/R8) trig",
                    k[1] ? "R6 (R3/R4) flag" : "R5 (R3/R4) flag");
            end
        end

        // R9 collision, sticky: rising event with a write of flag 0
        cyc(0, 0, 1'b1, 32'h0000_0025, "R9 setup", "R9 setup");
        cyc(0, 0, 1'b0, 32'h0, "R9 idle", "R9 idle");
        cyc(1, 0, 1'b1, 32'h0000_0025, "R9 sticky trig", "R9 hw wins sticky");
        // R9 collision, level mode: disabled falling edge with a write of flag 1
        cyc(1, 0, 1'b1, 32'h0000_0006, "R9 setup2", "R9 setup2");
        cyc(0, 0, 1'b1, 32'h0000_0086, "R9 level trig", "R9 hw wins level");
        // R9 plain software load with no edge
        cyc(0, 0, 1'b1, 32'h0000_0080, "R9 sw trig", "R9 sw load");

        // R8: select 5 with pulse enabled, rising event
        cyc(0, 0, 1'b1, 32'h0000_0055, "R8 setup", "R8 setup");
        cyc(1, 0, 1'b0, 32'h0, "R8 no output", "R8 flag");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule